// File: doc/BRIEF.md
# PCI configuration cycle router

This host bridge unit holds the configuration address word that software writes before it touches the configuration data window. When a data-window access arrives, the unit decodes the stored word and sends the access to one of three places: the two devices built into the bridge, the downstream hub link, or the secondary bridge port. For link and port traffic it also decides between Type 0 and Type 1 cycles and builds the address word that the later bus stage will drive.

Routing depends on where the bus number falls. Bus 0 belongs to the bridge's own devices and to the hub link. A bus number equal to the secondary bus number is decoded as a Type 0 access on the bridge port, with one IDSEL line chosen by the device number. Bus numbers above the secondary number and up to the subordinate number become Type 1 cycles on the port. Any other nonzero bus number goes to the hub link as a Type 1 cycle. A Type 0 port access to a device that has no IDSEL line is reported as a master abort.

The unit does not run the bus handshake. It presents one registered routing decision for each accepted data access.

Top module: `cfg_cycle_router`

## Requirements
- R1: The address register is written on `regWrEn` and read back on `regRdData` in the next cycle. Bit 31 (enable), bits 23:16 (bus), 15:11 (device), 10:8 (function) and 7:2 (register) are stored. Bits 30:24 and 1:0 always read as 0. Reset clears the whole register.
- R2: When the stored enable bit is 0, a `dataStrobe` starts no cycle. `routeValid` and `masterAbort` stay 0.
- R3: An accepted strobe gives a one-cycle `routeValid` pulse in the cycle after the strobe. The decision uses the register value from before any write made in the same cycle as the strobe. Between pulses the routing outputs hold their last value.
- R4: Bus 0 with device 0 or 1 gives `routeTarget` = 01 (internal), and `internalDevSel` equals the device number. Device 0 is claimed for any function number.
- R5: Bus 0 with any device other than 0 or 1 gives `routeTarget` = 10 (hub link) and `cycleType` = 0 (Type 0). The formed address holds device in 15:11, function in 10:8 and register in 7:2, with all other bits 0.
- R6: Bus 0, device 1 with a nonzero function number is not claimed: `routeValid` stays 0.
- R7: A nonzero bus number equal to `secBus` gives `routeTarget` = 11 (bridge port) and `cycleType` = 0.
- R8: A nonzero bus number greater than `secBus` and at most `subBus` gives `routeTarget` = 11 and `cycleType` = 1. Its address is bus in 23:16, device in 15:11, function in 10:8, register in 7:2, bits 1:0 = 01 and bits 31:24 = 0.
- R9: A nonzero bus number below `secBus` or above `subBus` gives `routeTarget` = 10 and `cycleType` = 1, with the same address layout as R8.
- R10: A port Type 0 access to device N, with N from 0 to 20, sets only address bit 11+N among bits 31:11, and bits 1:0 are 00.
- R11: A port Type 0 access to a device above 20 sets no bit in 31:11 and gives a one-cycle `masterAbort` pulse together with `routeValid`.
- R12: On every routed access, the function number appears in address bits 10:8 and the register number in bits 7:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Writes `regWrData` into the address register |
| regWrData | input | 32 | Address word to write |
| regRdData | output | 32 | Current address register contents |
| dataStrobe | input | 1 | Configuration data-window access |
| secBus | input | 8 | Secondary bus number of the bridge port |
| subBus | input | 8 | Subordinate bus number of the bridge port |
| routeValid | output | 1 | One-cycle pulse marking a routed access |
| routeTarget | output | 2 | 01 internal, 10 hub link, 11 bridge port |
| cycleType | output | 1 | 0 Type 0, 1 Type 1 |
| internalDevSel | output | 1 | Internal device number (0 or 1) |
| formedAddr | output | 32 | Address word for the chosen cycle |
| masterAbort | output | 1 | Pulse for a Type 0 port access with no IDSEL line |

## Verification
Four kinds of assertion are checked on every cycle:
- register writes read back with the reserved bits cleared;
- a disabled register or an unclaimed device-1 function never produces a pulse, and every pulse follows a strobe;
- every non-aborted port Type 0 address carries exactly one IDSEL bit, and an abort carries none;
- every Type 1 address ends in 01.

Only the bench scenarios can show which target each bus-number range selects, including the boundary buses equal to the secondary and subordinate numbers. They also show that device N lands on bit 11+N for all 21 devices, and that a strobe in the same cycle as a write uses the older register value.

// File: rtl/cfg_router_pkg.sv
package cfg_router_pkg;

  typedef enum logic [1:0] {
    TGT_NONE     = 2'b00,
    TGT_INTERNAL = 2'b01,
    TGT_HUB      = 2'b10,
    TGT_PORT     = 2'b11
  } target_e;

  typedef enum logic {
    CYC_T0 = 1'b0,
    CYC_T1 = 1'b1
  } cycle_e;

  // strobes and decisions passed from control to datapath
  typedef struct packed {
    logic    capture;
    target_e target;
    cycle_e  cycType;
    logic    abort;
    logic    devSel;
  } route_ctrl_t;

endpackage

// File: rtl/cfg_idsel_decode.sv
module cfg_idsel_decode #(
  parameter int DEV_W       = 5,
  parameter int IDSEL_LINES = 21
) (
  input  logic                   enable,
  input  logic [DEV_W-1:0]       devNum,
  output logic [IDSEL_LINES-1:0] idselLines
);

  // one comparator per address line; devices with no line leave all zero
  for (genvar g = 0; g < IDSEL_LINES; g++) begin : gLine
    assign idselLines[g] = enable && (devNum == DEV_W'(g));
  end

endmodule

// File: rtl/cfg_route_ctrl.sv
module cfg_route_ctrl
  import cfg_router_pkg::*;
#(
  parameter int BUS_W   = 8,
  parameter int DEV_W   = 5,
  parameter int FN_W    = 3,
  parameter int MAX_DEV = 20
) (
  input  logic             dataStrobe,
  input  logic             cfgEn,
  input  logic [BUS_W-1:0] busNum,
  input  logic [DEV_W-1:0] devNum,
  input  logic [FN_W-1:0]  fnNum,
  input  logic [BUS_W-1:0] secBus,
  input  logic [BUS_W-1:0] subBus,
  output route_ctrl_t      ctrl
);

  logic claim;

  always_comb begin
    claim        = 1'b1;
    ctrl.target  = TGT_NONE;
    ctrl.cycType = CYC_T0;
    ctrl.abort   = 1'b0;
    ctrl.devSel  = 1'b0;
    if (busNum == '0) begin
      if (devNum <= DEV_W'(1)) begin
        if (devNum[0] && (fnNum != '0)) begin
          claim = 1'b0;
        end else begin
          ctrl.target = TGT_INTERNAL;
          ctrl.devSel = devNum[0];
        end
      end else begin
        ctrl.target = TGT_HUB;
      end
    end else if (busNum == secBus) begin
      ctrl.target = TGT_PORT;
      ctrl.abort  = devNum > DEV_W'(MAX_DEV);
    end else if ((busNum > secBus) && (busNum <= subBus)) begin
      ctrl.target  = TGT_PORT;
      ctrl.cycType = CYC_T1;
    end else begin
      ctrl.target  = TGT_HUB;
      ctrl.cycType = CYC_T1;
    end
    ctrl.capture = dataStrobe && cfgEn && claim;
  end

endmodule

// File: rtl/cfg_route_datapath.sv
module cfg_route_datapath
  import cfg_router_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BUS_W  = 8,
  parameter int DEV_W  = 5,
  parameter int FN_W   = 3,
  parameter int REG_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regWrData,
  output logic [ADDR_W-1:0] regRdData,
  output logic              cfgEn,
  output logic [BUS_W-1:0]  busF,
  output logic [DEV_W-1:0]  devF,
  output logic [FN_W-1:0]   fnF,
  input  route_ctrl_t       ctrl,
  output logic              routeValid,
  output logic [1:0]        routeTarget,
  output logic              cycleType,
  output logic              internalDevSel,
  output logic [ADDR_W-1:0] formedAddr,
  output logic              masterAbort
);

  localparam int REG_LSB     = 2;
  localparam int FN_LSB      = REG_LSB + REG_W;
  localparam int DEV_LSB     = FN_LSB + FN_W;
  localparam int BUS_LSB     = DEV_LSB + DEV_W;
  localparam int FIELD_TOP   = BUS_LSB + BUS_W;
  localparam int IDSEL_LINES = ADDR_W - DEV_LSB;
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] RD_MASK =
      (ONE << (ADDR_W - 1)) | (((ONE << FIELD_TOP) - ONE) & ~((ONE << REG_LSB) - ONE));

  logic [REG_W-1:0]       regF;
  logic [IDSEL_LINES-1:0] idselLines;
  logic [ADDR_W-1:0]      nextAddr;
  logic                   unusedWrBits;

  assign unusedWrBits = ^{regWrData[ADDR_W-2:FIELD_TOP], regWrData[REG_LSB-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgEn <= 1'b0;
      busF  <= '0;
      devF  <= '0;
      fnF   <= '0;
      regF  <= '0;
    end else if (regWrEn) begin
      cfgEn <= regWrData[ADDR_W-1];
      busF  <= regWrData[BUS_LSB +: BUS_W];
      devF  <= regWrData[DEV_LSB +: DEV_W];
      fnF   <= regWrData[FN_LSB +: FN_W];
      regF  <= regWrData[REG_LSB +: REG_W];
    end
  end

  always_comb begin
    regRdData                       = '0;
    regRdData[ADDR_W-1]             = cfgEn;
    regRdData[BUS_LSB +: BUS_W]     = busF;
    regRdData[DEV_LSB +: DEV_W]     = devF;
    regRdData[FN_LSB +: FN_W]       = fnF;
    regRdData[REG_LSB +: REG_W]     = regF;
  end

  cfg_idsel_decode #(
    .DEV_W      (DEV_W),
    .IDSEL_LINES(IDSEL_LINES)
  ) uIdsel (
    .enable    ((ctrl.target == TGT_PORT) && (ctrl.cycType == CYC_T0)),
    .devNum    (devF),
    .idselLines(idselLines)
  );

  always_comb begin
    nextAddr                     = '0;
    nextAddr[FN_LSB +: FN_W]     = fnF;
    nextAddr[REG_LSB +: REG_W]   = regF;
    if (ctrl.cycType == CYC_T1) begin
      nextAddr[BUS_LSB +: BUS_W] = busF;
      nextAddr[DEV_LSB +: DEV_W] = devF;
      nextAddr[1:0]              = 2'b01;
    end else if (ctrl.target == TGT_PORT) begin
      nextAddr[ADDR_W-1:DEV_LSB] = idselLines;
    end else begin
      nextAddr[DEV_LSB +: DEV_W] = devF;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      routeValid     <= 1'b0;
      routeTarget    <= 2'b00;
      cycleType      <= 1'b0;
      internalDevSel <= 1'b0;
      formedAddr     <= '0;
      masterAbort    <= 1'b0;
    end else begin
      routeValid  <= ctrl.capture;
      masterAbort <= ctrl.capture && ctrl.abort;
      if (ctrl.capture) begin
        routeTarget    <= ctrl.target;
        cycleType      <= ctrl.cycType;
        internalDevSel <= ctrl.devSel;
        formedAddr     <= nextAddr;
      end
    end
  end

  // R1: write data returns with reserved bits cleared
  assert_readback_R1: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> regRdData == ($past(regWrData) & RD_MASK));

  // R10: non-aborted port Type 0 carries exactly one IDSEL line
  assert_idsel_onehot_R10: assert property (@(posedge clk) disable iff (!rstN)
    (routeValid && routeTarget == 2'b11 && !cycleType && !masterAbort) |->
      ($countones(formedAddr[ADDR_W-1:DEV_LSB]) == 1 && formedAddr[1:0] == 2'b00));

  // R11: abort only on a routed pulse with no IDSEL line
  assert_abort_noidsel_R11: assert property (@(posedge clk) disable iff (!rstN)
    masterAbort |-> (routeValid && formedAddr[ADDR_W-1:DEV_LSB] == '0));

  // R8: Type 1 addresses end in 01
  assert_type1_code_R8: assert property (@(posedge clk) disable iff (!rstN)
    (routeValid && cycleType) |-> formedAddr[1:0] == 2'b01);

endmodule

// File: rtl/cfg_cycle_router.sv
module cfg_cycle_router
  import cfg_router_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BUS_W  = 8,
  parameter int DEV_W  = 5,
  parameter int FN_W   = 3,
  parameter int REG_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regWrData,
  output logic [ADDR_W-1:0] regRdData,
  input  logic              dataStrobe,
  input  logic [BUS_W-1:0]  secBus,
  input  logic [BUS_W-1:0]  subBus,
  output logic              routeValid,
  output logic [1:0]        routeTarget,
  output logic              cycleType,
  output logic              internalDevSel,
  output logic [ADDR_W-1:0] formedAddr,
  output logic              masterAbort
);

  localparam int DEV_LSB = 2 + REG_W + FN_W;
  localparam int MAX_DEV = ADDR_W - DEV_LSB - 1;

  route_ctrl_t            ctrl;
  logic                   cfgEn;
  logic [BUS_W-1:0]       busF;
  logic [DEV_W-1:0]       devF;
  logic [FN_W-1:0]        fnF;

  cfg_route_ctrl #(
    .BUS_W  (BUS_W),
    .DEV_W  (DEV_W),
    .FN_W   (FN_W),
    .MAX_DEV(MAX_DEV)
  ) uCtrl (
    .dataStrobe(dataStrobe),
    .cfgEn     (cfgEn),
    .busNum    (busF),
    .devNum    (devF),
    .fnNum     (fnF),
    .secBus    (secBus),
    .subBus    (subBus),
    .ctrl      (ctrl)
  );

  cfg_route_datapath #(
    .ADDR_W(ADDR_W),
    .BUS_W (BUS_W),
    .DEV_W (DEV_W),
    .FN_W  (FN_W),
    .REG_W (REG_W)
  ) uPath (
    .clk           (clk),
    .rstN          (rstN),
    .regWrEn       (regWrEn),
    .regWrData     (regWrData),
    .regRdData     (regRdData),
    .cfgEn         (cfgEn),
    .busF          (busF),
    .devF          (devF),
    .fnF           (fnF),
    .ctrl          (ctrl),
    .routeValid    (routeValid),
    .routeTarget   (routeTarget),
    .cycleType     (cycleType),
    .internalDevSel(internalDevSel),
    .formedAddr    (formedAddr),
    .masterAbort   (masterAbort)
  );

  // R2: a disabled register never yields a pulse
  assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    (dataStrobe && !regRdData[ADDR_W-1]) |=> (!routeValid && !masterAbort));

  // R6: device 1 with nonzero function is not claimed
  assert_fn_ignored_R6: assert property (@(posedge clk) disable iff (!rstN)
    (dataStrobe && regRdData[ADDR_W-2:DEV_LSB+DEV_W] == '0 &&
     regRdData[DEV_LSB +: DEV_W] == DEV_W'(1) && regRdData[DEV_LSB-1:2+REG_W] != '0)
      |=> !routeValid);

  // R3: every pulse follows a strobe one cycle earlier
  assert_valid_follows_R3: assert property (@(posedge clk) disable iff (!rstN)
    routeValid |-> $past(dataStrobe));

endmodule

// File: tb/tb_cfg_cycle_router.sv
module tb_cfg_cycle_router;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic        dataStrobe;
  logic [7:0]  secBus;
  logic [7:0]  subBus;
  logic        routeValid;
  logic [1:0]  routeTarget;
  logic        cycleType;
  logic        internalDevSel;
  logic [31:0] formedAddr;
  logic        masterAbort;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  cfg_cycle_router dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .dataStrobe(dataStrobe), .secBus(secBus),
    .subBus(subBus), .routeValid(routeValid), .routeTarget(routeTarget),
    .cycleType(cycleType), .internalDevSel(internalDevSel),
    .formedAddr(formedAddr), .masterAbort(masterAbort)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      mismatched = mismatched + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<20000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  function automatic logic [31:0] mkAddr(input logic en, input logic [7:0] bus,
                                          input logic [4:0] dev, input logic [2:0] fn,
                                          input logic [5:0] rg);
    return {en, 7'b0, bus, dev, fn, rg, 2'b00};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared = compared + 1;
    if (act !== exp) begin
      mismatched = mismatched + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // compare the whole routing result: {valid, target, type, devSel, abort, addr}
  task automatic checkRoute(input string req, input logic v, input logic [1:0] t,
                            input logic c, input logic ds, input logic ab,
                            input logic [31:0] a);
    if (!v)
      check(req, {62'b0, routeValid, masterAbort}, 64'b0);
    else
      check(req, {27'b0, routeValid, routeTarget, cycleType, internalDevSel, masterAbort, formedAddr},
                 {27'b0, 1'b1, t, c, ds, ab, a});
  endtask

  task automatic writeReg(input logic [31:0] w);
    @(negedge clk);
    regWrEn = 1'b1; regWrData = w;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic strobe();
    dataStrobe = 1'b1;
    @(negedge clk);
    dataStrobe = 1'b0;
  endtask

  task automatic access(input logic [31:0] w);
    writeReg(w);
    strobe();
  endtask

  task automatic testReset();
    check("R1 reset readback", {32'b0, regRdData}, 64'b0);
    checkRoute("R3 reset outputs", 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 32'b0);
    check("R3 reset addr", {30'b0, routeTarget, formedAddr}, 64'b0);
  endtask

  task automatic testRegister();
    writeReg(32'hFFFF_FFFF);
    check("R1 reserved bits read zero", {32'b0, regRdData}, {32'b0, 32'h80FF_FFFC});
    writeReg(32'h7F00_0003);
    check("R1 reserved-only write", {32'b0, regRdData}, 64'b0);
  endtask

  task automatic testDisabled();
    access(mkAddr(1'b0, 8'h00, 5'd0, 3'd0, 6'd1));
    checkRoute("R2 disabled internal", 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 32'b0);
    access(mkAddr(1'b0, 8'h02, 5'd25, 3'd0, 6'd1));
    checkRoute("R2 disabled abort case", 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 32'b0);
  endtask

  task automatic testInternal();
    access(mkAddr(1'b1, 8'h00, 5'd0, 3'd0, 6'd4));
    checkRoute("R4 dev0", 1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 32'h0000_0010);
    access(mkAddr(1'b1, 8'h00, 5'd1, 3'd0, 6'd7));
    checkRoute("R4 dev1 fn0", 1'b1, 2'b01, 1'b0, 1'b1, 1'b0, 32'h0000_081C);
    access(mkAddr(1'b1, 8'h00, 5'd0, 3'd3, 6'd0));
    checkRoute("R4 dev0 fn3 claimed", 1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 32'h0000_0300);
    access(mkAddr(1'b1, 8'h00, 5'd1, 3'd2, 6'd0));
    checkRoute("R6 dev1 fn2 ignored", 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 32'b0);
    access(mkAddr(1'b1, 8'h00, 5'd1, 3'd7, 6'd63));
    checkRoute("R6 dev1 fn7 ignored", 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 32'b0);
  endtask

  task automatic testHubBus0();
    access(mkAddr(1'b1, 8'h00, 5'd5, 3'd1, 6'd3));
    checkRoute("R5 R12 bus0 dev5 hub", 1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 32'h0000_290C);
    access(mkAddr(1'b1, 8'h00, 5'd31, 3'd7, 6'd63));
    checkRoute("R5 bus0 dev31 hub", 1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 32'h0000_FFFC);
  endtask

  task automatic testPortType0();
    for (int d = 0; d <= 20; d++) begin
      access(mkAddr(1'b1, 8'h02, 5'(d), 3'd2, 6'd1));
      checkRoute("R7 R10 R12 port type0 idsel", 1'b1, 2'b11, 1'b0, 1'b0, 1'b0,
                 (32'h1 << (11 + d)) | 32'h0000_0204);
    end
    access(mkAddr(1'b1, 8'h02, 5'd20, 3'd5, 6'd9));
    checkRoute("R10 dev20 bit31", 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 32'h8000_0524);
  endtask

  task automatic testAbort();
    access(mkAddr(1'b1, 8'h02, 5'd21, 3'd2, 6'd1));
    checkRoute("R11 dev21 abort", 1'b1, 2'b11, 1'b0, 1'b0, 1'b1, 32'h0000_0204);
    @(negedge clk);
    check("R11 abort is one pulse", {62'b0, routeValid, masterAbort}, 64'b0);
    access(mkAddr(1'b1, 8'h02, 5'd31, 3'd0, 6'd0));
    checkRoute("R11 dev31 abort", 1'b1, 2'b11, 1'b0, 1'b0, 1'b1, 32'h0000_0000);
  endtask

  task automatic testRanges();
    access(mkAddr(1'b1, 8'h04, 5'd3, 3'd1, 6'd2));
    checkRoute("R8 bus4 port type1", 1'b1, 2'b11, 1'b1, 1'b0, 1'b0, 32'h0004_1909);
    access(mkAddr(1'b1, 8'h05, 5'd31, 3'd0, 6'd0));
    checkRoute("R8 bus5 equals subordinate", 1'b1, 2'b11, 1'b1, 1'b0, 1'b0, 32'h0005_F801);
    access(mkAddr(1'b1, 8'h06, 5'd3, 3'd1, 6'd2));
    checkRoute("R9 bus6 above subordinate", 1'b1, 2'b10, 1'b1, 1'b0, 1'b0, 32'h0006_1909);
    access(mkAddr(1'b1, 8'h01, 5'd0, 3'd4, 6'd5));
    checkRoute("R9 bus1 below secondary", 1'b1, 2'b10, 1'b1, 1'b0, 1'b0, 32'h0001_0415);
    access(mkAddr(1'b1, 8'hFF, 5'd2, 3'd0, 6'd0));
    checkRoute("R9 bus255 hub type1", 1'b1, 2'b10, 1'b1, 1'b0, 1'b0, 32'h00FF_1001);
  endtask

  task automatic testTiming();
    writeReg(mkAddr(1'b1, 8'h00, 5'd0, 3'd0, 6'd2));
    @(negedge clk);
    regWrEn = 1'b1; regWrData = mkAddr(1'b1, 8'h00, 5'd5, 3'd0, 6'd0);
    dataStrobe = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; dataStrobe = 1'b0;
    checkRoute("R3 strobe uses older value", 1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 32'h0000_0008);
    @(negedge clk);
    check("R3 pulse lasts one cycle", {63'b0, routeValid}, 64'b0);
    check("R3 outputs hold", {29'b0, routeTarget, cycleType, formedAddr},
          {29'b0, 2'b01, 1'b0, 32'h0000_0008});
    strobe();
    checkRoute("R3 new value next strobe", 1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 32'h0000_2800);
  endtask

  initial begin
    rstN = 1'b0; regWrEn = 1'b0; regWrData = '0; dataStrobe = 1'b0;
    secBus = 8'h02; subBus = 8'h05;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRegister();
    testDisabled();
    testInternal();
    testHubBus0();
    testPortType0();
    testAbort();
    testRanges();
    testTiming();
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule